// File: doc/BRIEF.md
# Neighbour-Inclusive Threshold Suppressor

This block reduces one event's worth of calorimeter cell data to the few cells worth reading out. The cells sit on a rectangular grid (32 × 32 by default). Each cell holds a 12-bit amplitude and 8 trigger bits. Before an event is processed, the whole frame is written into the block's local cell store. A start pulse then opens the processing of that event.

Processing takes two passes over the store. The first pass compares each amplitude with a high threshold and records the cells that pass as seeds. Every cell that is a seed, or touches a seed along an edge or a corner, is selected. The second pass walks the addresses in ascending order and sends each selected cell exactly once. Each cell goes out as a 32-bit word on a valid/ready stream.

While an event is in progress the block reports busy. Frame writes and new start pulses are not accepted until the previous event has fully drained.

Top module: `cell_halo_suppressor`

## Requirements
- R1: After reset, `busy` and `out_valid` are low.
- R2: A cell write (`wr_en`) updates the store only while `busy` is low. A write presented while `busy` is high leaves the stored cell unchanged, and that is visible in the words of later events.
- R3: A cell is a seed only when its amplitude is strictly greater than the threshold. An amplitude equal to the threshold does not seed.
- R4: A cell is emitted when it is a seed or when any of its up to 8 grid neighbours (row ±1, column ±1) is a seed. Neighbour positions outside the grid are ignored, and there is no wrap: the last column of one row does not neighbour the first column of the next row. Cell index = row × GRID_W + column.
- R5: The selected cells of an event are emitted once each, in strictly ascending index order, and no unselected cell is emitted.
- R6: Word layout: bits 31:20 are the cell index zero-extended to 12 bits, bits 19:8 are the stored amplitude, and bits 7:0 are the stored trigger bits.
- R7: The threshold is captured from `thr_cfg` when a start is accepted. Changes to `thr_cfg` while `busy` is high do not affect that event.
- R8: A `frame_go` pulse seen while `busy` is low starts an event, and `busy` is high from the next cycle until the last word is accepted. A `frame_go` seen while `busy` is high is ignored and does not start another event.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` holds its value on the next cycle.
- R10: `busy` stays high for exactly 2 × GRID_W × GRID_H cycles plus the number of cycles in which `out_valid` is high and `out_ready` is low. At the default grid and 250 MHz, that is 8.2 µs per event without back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_cfg | input | 12 | Seed threshold, captured when a start is accepted |
| wr_en | input | 1 | Cell write strobe (honoured only while not busy) |
| wr_cell | input | log2(GRID_W×GRID_H) | Cell index to write |
| wr_amp | input | 12 | Amplitude to store |
| wr_trig | input | 8 | Trigger bits to store |
| frame_go | input | 1 | Start processing the stored frame |
| busy | output | 1 | Event in progress |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | 32 | Packed index, amplitude and trigger bits |

## Verification
The assertions assume a well-behaved environment:
- `frame_go` and the writes are not relied on during busy.
- `out_ready` may vary freely.
- `thr_cfg` is meaningful only in the cycle a start is accepted.

The ordering and cycle-count properties also assume that each event runs to completion from a reset state. The stimulus follows these assumptions in the following ways:
- It writes the frame only while idle, apart from deliberate writes made during busy to show that they are dropped.
- It pulses `frame_go` for one cycle.
- It toggles `out_ready` in a fixed pattern that never blocks forever.

Against this stimulus, the bench's model recomputes the dilated selection from its own copy of the frame.

// File: rtl/chs_pkg.sv
package chs_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned AMP_W  = 12;
  localparam int unsigned TRIG_W = 8;
  localparam int unsigned WORD_W = ADDR_W + AMP_W + TRIG_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEED = 2'd1,
    ST_EMIT = 2'd2
  } chs_state_e;

  // Seed test: strictly above the threshold.
  function automatic logic chs_seeds(input logic [AMP_W-1:0] amp,
                                     input logic [AMP_W-1:0] thr);
    return amp > thr;
  endfunction

  // Output word: index on top, amplitude in the middle, trigger bits low.
  function automatic logic [WORD_W-1:0] chs_pack(input logic [ADDR_W-1:0] addr,
                                                 input logic [AMP_W-1:0]  amp,
                                                 input logic [TRIG_W-1:0] trig);
    return {addr, amp, trig};
  endfunction
endpackage

// File: rtl/chs_cell_store.sv
module chs_cell_store
  import chs_pkg::*;
#(
  parameter int unsigned CELLS = 1024,
  localparam int unsigned IDX_W = $clog2(CELLS),
  localparam int unsigned ENT_W = AMP_W + TRIG_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [AMP_W-1:0]  wr_amp,
  input  logic [TRIG_W-1:0] wr_trig,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [AMP_W-1:0]  rd_amp,
  output logic [TRIG_W-1:0] rd_trig
);
  logic [ENT_W-1:0] cells_q [CELLS];

  always_ff @(posedge clk) begin
    if (wr_en) cells_q[wr_idx] <= {wr_amp, wr_trig};
  end

  assign rd_amp  = cells_q[rd_idx][ENT_W-1:TRIG_W];
  assign rd_trig = cells_q[rd_idx][TRIG_W-1:0];
endmodule

// File: rtl/chs_halo_dilate.sv
module chs_halo_dilate #(
  parameter int unsigned GRID_W = 32,
  parameter int unsigned GRID_H = 32,
  localparam int unsigned CELLS = GRID_W * GRID_H
) (
  input  logic [CELLS-1:0] seed,
  output logic [CELLS-1:0] mask
);
  // Bit i is set when cell i lies in the given column.
  function automatic logic [CELLS-1:0] col_sel(input int unsigned col);
    logic [CELLS-1:0] v;
    v = '0;
    for (int unsigned i = 0; i < CELLS; i++) v[i] = ((i % GRID_W) == col);
    return v;
  endfunction

  localparam logic [CELLS-1:0] COL_FIRST = col_sel(0);
  localparam logic [CELLS-1:0] COL_LAST  = col_sel(GRID_W - 1);

  logic [CELLS-1:0] row_spread;

  generate
    if (GRID_W > 1) begin : g_wide
      // Horizontal pass; the column masks block wrap between rows.
      assign row_spread = seed
                        | ((seed << 1) & ~COL_FIRST)
                        | ((seed >> 1) & ~COL_LAST);
    end else begin : g_narrow
      assign row_spread = seed;
    end

    if (GRID_H > 1) begin : g_tall
      // Vertical pass; shifts past the grid edge fall off.
      assign mask = row_spread
                  | (row_spread << GRID_W)
                  | (row_spread >> GRID_W);
    end else begin : g_flat
      assign mask = row_spread;
    end
  endgenerate
endmodule

// File: rtl/chs_scan_ctrl.sv
module chs_scan_ctrl
  import chs_pkg::*;
#(
  parameter int unsigned CELLS = 1024,
  localparam int unsigned IDX_W = $clog2(CELLS),
  localparam int unsigned CNT_W = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_go,
  input  logic [AMP_W-1:0] thr_cfg,
  input  logic [AMP_W-1:0] rd_amp,
  input  logic [CELLS-1:0] mask,
  input  logic             out_ready,
  output logic [IDX_W-1:0] idx,
  output logic [CELLS-1:0] seed,
  output logic             busy,
  output logic             out_valid
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELLS - 1);

  chs_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [AMP_W-1:0] thr_q;
  logic [CELLS-1:0] seed_q;

  // Named events for the assertions.
  logic go_taken, seed_step, emit_step, word_fire, stall, frame_done;

  assign go_taken   = (state_q == ST_IDLE) && frame_go;
  assign seed_step  = (state_q == ST_SEED);
  assign emit_step  = (state_q == ST_EMIT) && (!mask[idx_q] || out_ready);
  assign word_fire  = (state_q == ST_EMIT) && mask[idx_q] && out_ready;
  assign stall      = (state_q == ST_EMIT) && mask[idx_q] && !out_ready;
  assign frame_done = emit_step && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      thr_q   <= '0;
      seed_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (frame_go) begin
            state_q <= ST_SEED;
            idx_q   <= '0;
            thr_q   <= thr_cfg;
          end
        end
        ST_SEED: begin
          seed_q[idx_q] <= chs_seeds(rd_amp, thr_q);
          if (idx_q == LAST_IDX) begin
            state_q <= ST_EMIT;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_EMIT: begin
          if (emit_step) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_IDLE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx       = idx_q;
  assign seed      = seed_q;
  assign busy      = (state_q != ST_IDLE);
  assign out_valid = (state_q == ST_EMIT) && mask[idx_q];

  // ---------------- checker state and assertions ----------------
  logic [IDX_W-1:0] last_fired_q;
  logic             fired_q;
  logic [CNT_W-1:0] run_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_fired_q <= '0;
      fired_q      <= 1'b0;
      run_cnt_q    <= '0;
    end else begin
      if (go_taken) begin
        fired_q   <= 1'b0;
        run_cnt_q <= '0;
      end else begin
        if (word_fire) begin
          fired_q      <= 1'b1;
          last_fired_q <= idx_q;
        end
        if (busy && !stall) run_cnt_q <= run_cnt_q + 1'b1;
      end
    end
  end

  p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_fire && fired_q) |-> (idx_q > last_fired_q));

  p_thr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(thr_q));

  p_busy_until_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> busy);

  p_frame_cycles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (run_cnt_q == CNT_W'(2 * CELLS - 1)));
endmodule

// File: rtl/cell_halo_suppressor.sv
module cell_halo_suppressor
  import chs_pkg::*;
#(
  parameter int unsigned GRID_W = 32,
  parameter int unsigned GRID_H = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [11:0]                         thr_cfg,
  input  logic                                wr_en,
  input  logic [$clog2(GRID_W*GRID_H)-1:0]    wr_cell,
  input  logic [11:0]                         wr_amp,
  input  logic [7:0]                          wr_trig,
  input  logic                                frame_go,
  output logic                                busy,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [31:0]                         out_word
);
  localparam int unsigned CELLS = GRID_W * GRID_H;
  localparam int unsigned IDX_W = $clog2(CELLS);

  logic [IDX_W-1:0]  scan_idx;
  logic [AMP_W-1:0]  cell_amp;
  logic [TRIG_W-1:0] cell_trig;
  logic [CELLS-1:0]  seed_vec;
  logic [CELLS-1:0]  sel_mask;
  logic              store_we;

  // Writes are dropped while an event is in flight.
  assign store_we = wr_en && !busy;

  chs_cell_store #(.CELLS(CELLS)) u_store (
    .clk     (clk),
    .wr_en   (store_we),
    .wr_idx  (wr_cell),
    .wr_amp  (wr_amp),
    .wr_trig (wr_trig),
    .rd_idx  (scan_idx),
    .rd_amp  (cell_amp),
    .rd_trig (cell_trig)
  );

  chs_halo_dilate #(.GRID_W(GRID_W), .GRID_H(GRID_H)) u_dilate (
    .seed (seed_vec),
    .mask (sel_mask)
  );

  chs_scan_ctrl #(.CELLS(CELLS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_go  (frame_go),
    .thr_cfg   (thr_cfg),
    .rd_amp    (cell_amp),
    .mask      (sel_mask),
    .out_ready (out_ready),
    .idx       (scan_idx),
    .seed      (seed_vec),
    .busy      (busy),
    .out_valid (out_valid)
  );

  assign out_word = chs_pack(ADDR_W'(scan_idx), cell_amp, cell_trig);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
endmodule

// File: tb/test_cell_halo_suppressor.sv
`timescale 1ns/1ps
module test_cell_halo_suppressor;
  localparam int GW = 32;
  localparam int GH = 32;
  localparam int NC = GW * GH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] thr_cfg = '0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_cell = '0;
  logic [11:0] wr_amp = '0;
  logic [7:0]  wr_trig = '0;
  logic        frame_go = 1'b0;
  logic        busy, out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;

  int tests = 0;
  int fails = 0;
  int amp_m [NC];
  int trig_m [NC];

  always #2 clk = ~clk;

  cell_halo_suppressor #(.GRID_W(GW), .GRID_H(GH)) i_cell_halo_suppressor (
    .clk(clk), .rst_n(rst_n), .thr_cfg(thr_cfg), .wr_en(wr_en),
    .wr_cell(wr_cell), .wr_amp(wr_amp), .wr_trig(wr_trig),
    .frame_go(frame_go), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit selected(input int i, input int thr);
    int r = i / GW;
    int c = i % GW;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++) begin
        int nr = r + dr;
        int nc = c + dc;
        if (nr >= 0 && nr < GH && nc >= 0 && nc < GW)
          if (amp_m[nr*GW + nc] > thr) return 1'b1;
      end
    return 1'b0;
  endfunction

  task automatic write_cell(input int i, input int a, input int t);
    wr_en = 1'b1; wr_cell = 10'(i); wr_amp = 12'(a); wr_trig = 8'(t);
    @(negedge clk);
    wr_en = 1'b0;
    amp_m[i] = a; trig_m[i] = t;
  endtask

  // disturb: 0 none, 1 threshold change, 2 write while busy, 3 start while busy
  task automatic run_event(input int thr, input bit stall_on, input int disturb,
                           input string tag);
    int exp_q[$];
    int busy_cycles = 0;
    int stalls = 0;
    int got = 0;
    bit pend = 1'b0;
    logic [31:0] held = '0;
    for (int i = 0; i < NC; i++) if (selected(i, thr)) exp_q.push_back(i);
    thr_cfg = 12'(thr);
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    forever begin
      if (!busy) break;
      busy_cycles++;
      if (disturb == 1 && busy_cycles == 5) thr_cfg = 12'd0;
      if (disturb == 2 && busy_cycles == 5) begin
        wr_en = 1'b1; wr_cell = 10'd700; wr_amp = 12'hFFF; wr_trig = 8'hAA;
      end
      if (disturb == 2 && busy_cycles == 6) wr_en = 1'b0;
      if (disturb == 3 && (busy_cycles == 5 || busy_cycles == 2040)) frame_go = 1'b1;
      if (disturb == 3 && (busy_cycles == 6 || busy_cycles == 2041)) frame_go = 1'b0;
      out_ready = stall_on ? ((busy_cycles % 3) != 0) : 1'b1;
      if (pend) begin
        chk(out_valid && out_word == held, "R9", "held word", out_word, held);
        pend = 1'b0;
      end
      if (out_valid) begin
        if (out_ready) begin
          if (got < exp_q.size()) begin
            int e = exp_q[got];
            logic [31:0] ew = {12'(e), 12'(amp_m[e]), 8'(trig_m[e])};
            chk(out_word == ew, {tag, " R6"}, "word", out_word, ew);
          end else begin
            chk(1'b0, {tag, " R5"}, "extra word", out_word, 0);
          end
          got++;
        end else begin
          stalls++;
          pend = 1'b1;
          held = out_word;
        end
      end
      @(negedge clk);
    end
    out_ready = 1'b1;
    frame_go = 1'b0;
    chk(got == exp_q.size(), {tag, " R5"}, "word count", got, exp_q.size());
    chk(busy_cycles == 2*NC + stalls, "R10", "busy cycles", busy_cycles, 2*NC + stalls);
    if (disturb == 3) begin
      for (int k = 0; k < 3; k++) begin
        chk(!busy, "R8", "no restart after ignored start", busy, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R1", "idle after release", {busy, out_valid}, 0);

    // Background frame, all below 150
    for (int i = 0; i < NC; i++) write_cell(i, (i * 13) % 90, (i * 29 + 5) & 255);

    run_event(150, 1'b0, 0, "R3 none");
    run_event(0, 1'b1, 0, "R3 thr0");            // everything selected, back-pressure
    write_cell(500, 200, 8'h3C);
    run_event(200, 1'b0, 0, "R3 equal");          // equal does not seed
    write_cell(500, 201, 8'h3C);
    run_event(200, 1'b1, 0, "R3 above");          // 9 cells
    write_cell(500, 40, 8'h3C);

    // Sweep of single seeds incl. corners and edges (R4 no-wrap)
    begin
      int pos[$] = '{0, 31, 32, 63, 992, 1023, 1, 33, 527, 991};
      for (int k = 1; k <= 14; k++) pos.push_back((k * 97) % NC);
      foreach (pos[j]) begin
        int p = pos[j];
        int a0 = amp_m[p];
        int t0 = trig_m[p];
        write_cell(p, 4000, 8'h80 | (p & 8'h7F));
        run_event(150, j[0], 0, "R4");
        write_cell(p, a0, t0);
      end
    end

    // Overlapping seeds
    write_cell(100, 3000, 1);
    write_cell(101, 3001, 2);
    write_cell(134, 3002, 3);
    write_cell(1023, 3003, 4);
    run_event(150, 1'b1, 0, "R4 overlap");

    // Threshold change during busy ignored
    run_event(150, 1'b0, 1, "R7");

    // Write during busy ignored, visible in a later event
    write_cell(700, 10, 8'h11);
    run_event(150, 1'b0, 2, "R2 during");
    run_event(150, 1'b0, 0, "R2 after");

    // Start pulses while busy ignored
    run_event(150, 1'b1, 3, "R8");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule